// File: doc/BRIEF.md
# General-Purpose Event Status and Interrupt Routing

This block holds a 32-bit sticky event status word and a matching 32-bit enable word. The upper sixteen status bits follow sixteen general-purpose input pins. Each pin has its own input-mode qualifier, polarity invert and 2-bit interrupt route. The lower sixteen bits are set by hardware event strobes. One of them, bit 14, is a USB wake source, and bit 15 is reserved. Software reads either word through a small register port. It clears status bits by writing ones to the status word and writes the enable word directly.

An event that is both pending and enabled raises a wake request while the system is in any sleep state. While it is running, the same event raises an SCI or an SMI instead. Lower-half events pick between the two using the global SCI enable. General-purpose inputs also pass through their own route field. Two resets exist. The resume-well reset clears everything. The reset-control pulse clears only the upper (GPI) half of the status word.

Top module: `gpe_event_router`

## Requirements
- R1: While `rst` is high at a clock edge, the status and enable words become 0, and with them `wake_req`, `sci_req` and `smi_req` read 0.
- R2: At each clock edge, status bit 16+n becomes 1 when `gpi_is_input[n]` is 1 and `gpi_pin[n]` XOR `gpi_invert[n]` is 1. So GPI 0 maps to bit 16 and GPI 15 maps to bit 31. A pin not marked as an input never sets its bit.
- R3: A status bit stays 1 after its source goes inactive, until it is cleared.
- R4: A write with `reg_addr`=0 (status) clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R5: When a source sets a bit in the same cycle that a write-1 clears it, the bit ends up 1.
- R6: A `soft_rst` pulse clears status bits 31:16 at the next edge and keeps bits 15:0.
- R7: Status bit 15 always reads 0, whatever the hardware strobes or writes do. Enable bit 15 reads 0 after any write.
- R8: Strobe `hw_set[14]` sets status bit 14, the USB wake status. With enable bit 14 set, that bit produces a wake request while sleeping, and a write-1 clears it.
- R9: `wake_req` is 1 exactly when `pwr_state` is not 0 (S1 to S5 are codes 1 to 5) and some status bit is set together with its enable bit. No SCI or SMI is raised while sleeping.
- R10: In S0 (`pwr_state`=0), an enabled pending bit in 15:0 raises `sci_req` when `sci_en` is 1 and `smi_req` when `sci_en` is 0.
- R11: In S0, an enabled pending GPI n uses route field `gpi_route[2n+1:2n]`. Code 00 raises nothing. Code 01 raises SMI. Code 10 raises SCI when `sci_en` is 1 and SMI when it is 0. Code 11 raises nothing.
- R12: A write with `reg_addr`=1 loads the enable word, which then reads back on `reg_rdata` with `reg_addr`=1, and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Resume-well reset, synchronous, active high; clears status and enable |
| soft_rst | input | 1 | Reset-control pulse; clears the GPI half of the status word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data (write-1-to-clear for status) |
| reg_rdata | output | 32 | Read data of the selected register |
| gpi_pin | input | 16 | Raw general-purpose input levels |
| gpi_is_input | input | 16 | Per-pin input-mode qualifier |
| gpi_invert | input | 16 | Per-pin polarity invert |
| gpi_route | input | 32 | Per-pin 2-bit interrupt route |
| hw_set | input | 16 | Hardware event strobes for status bits 15:0 |
| pwr_state | input | 3 | Current power state, 0 = S0, 1..5 = S1..S5 |
| sci_en | input | 1 | Global SCI enable; 0 selects SMI |
| wake_req | output | 1 | Wake request while sleeping |
| sci_req | output | 1 | SCI request while running |
| smi_req | output | 1 | SMI request while running |

## Verification
The status bits are sticky, so a stuck or lost bit shows on `reg_rdata` at the first status read after the edge that should have set or cleared it. A wrong bit also shows one cycle later on whichever of the three request outputs the power state and route select. The request outputs are combinational from the stored words. A wrong route decode or power-state qualification therefore appears on the same cycle that `pwr_state`, `sci_en` or the route field changes.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    localparam int GPI_COUNT = 16;

    typedef enum logic [2:0] {
        PS_S0 = 3'd0,
        PS_S1 = 3'd1,
        PS_S2 = 3'd2,
        PS_S3 = 3'd3,
        PS_S4 = 3'd4,
        PS_S5 = 3'd5
    } pwr_state_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_RSVD = 2'b11
    } gpi_route_e;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic sci;
        logic smi;
    } irq_pair_t;

    // Running-state interrupt class for one GPI given its route code.
    function automatic irq_pair_t route_decode(gpi_route_e rt, logic sci_enable);
        irq_pair_t r;
        r = '0;
        case (rt)
            RT_SMI: r.smi = 1'b1;
            RT_SCI: begin
                r.sci = sci_enable;
                r.smi = !sci_enable;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpe_gpi_detect.sv
module gpe_gpi_detect #(
    parameter int GPI_N = gpe_pkg::GPI_COUNT
) (
    input  logic [GPI_N-1:0] gpi_pin,
    input  logic [GPI_N-1:0] gpi_is_input,
    input  logic [GPI_N-1:0] gpi_invert,
    output logic [GPI_N-1:0] gpi_active
);

    for (genvar n = 0; n < GPI_N; n++) begin : g_pin
        assign gpi_active[n] = gpi_is_input[n] & (gpi_pin[n] ^ gpi_invert[n]);
    end

endmodule

// File: rtl/gpe_status_regs.sv
module gpe_status_regs #(
    parameter int               REG_W     = 32,
    parameter int               LOW_W     = 16,
    parameter logic [REG_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] enable_q
);

    logic [REG_W-1:0] status_nxt;

    always_comb begin
        status_nxt = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;
        if (soft_rst) begin
            status_nxt[REG_W-1:LOW_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_nxt;
            if (en_wr) begin
                enable_q <= en_wdata & IMPL_MASK;
            end
        end
    end

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~IMPL_MASK) == '0) && ((enable_q & ~IMPL_MASK) == '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ((|(set_vec & IMPL_MASK)) && !soft_rst)
        |=> ((status_q & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

    assert_soft_clear_R6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (status_q[REG_W-1:LOW_W] == '0));

endmodule

// File: rtl/gpe_req_logic.sv
module gpe_req_logic
    import gpe_pkg::*;
#(
    parameter int GPI_N = gpe_pkg::GPI_COUNT,
    parameter int LOW_W = 16,
    localparam int REG_W = LOW_W + GPI_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_W-1:0]   status_q,
    input  logic [REG_W-1:0]   enable_q,
    input  logic [2*GPI_N-1:0] gpi_route,
    input  logic [2:0]         pwr_state,
    input  logic               sci_en,
    output logic               wake_req,
    output logic               sci_req,
    output logic               smi_req
);

    logic [REG_W-1:0] pend;
    logic [GPI_N-1:0] gpi_sci;
    logic [GPI_N-1:0] gpi_smi;
    logic             sleeping;
    logic             low_any;

    assign pend     = status_q & enable_q;
    assign sleeping = (pwr_state != PS_S0);
    assign low_any  = |pend[LOW_W-1:0];

    for (genvar n = 0; n < GPI_N; n++) begin : g_route
        irq_pair_t cls;
        assign cls        = route_decode(gpi_route_e'(gpi_route[2*n+1:2*n]), sci_en);
        assign gpi_sci[n] = pend[LOW_W+n] & cls.sci;
        assign gpi_smi[n] = pend[LOW_W+n] & cls.smi;
    end

    assign wake_req = sleeping & (|pend);
    assign sci_req  = !sleeping & ((low_any & sci_en) | (|gpi_sci));
    assign smi_req  = !sleeping & ((low_any & !sci_en) | (|gpi_smi));

    assert_no_wake_running_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_S0) |-> !wake_req);

    assert_no_irq_sleeping_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != PS_S0) |-> (!sci_req && !smi_req));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((status_q & enable_q) == '0) |-> (!wake_req && !sci_req && !smi_req));

    assert_smi_route_R11: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == PS_S0) && status_q[LOW_W] && enable_q[LOW_W]
         && (gpi_route[1:0] == RT_SMI)) |-> smi_req);

endmodule

// File: rtl/gpe_event_router.sv
module gpe_event_router
    import gpe_pkg::*;
#(
    parameter int GPI_N = gpe_pkg::GPI_COUNT,
    parameter logic [GPI_N-1:0] LOW_SRC_MASK = 16'h7FFF,
    localparam int LOW_W = GPI_N,
    localparam int REG_W = LOW_W + GPI_N,
    localparam logic [REG_W-1:0] IMPL_MASK = {{GPI_N{1'b1}}, LOW_SRC_MASK}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [GPI_N-1:0]   gpi_pin,
    input  logic [GPI_N-1:0]   gpi_is_input,
    input  logic [GPI_N-1:0]   gpi_invert,
    input  logic [2*GPI_N-1:0] gpi_route,
    input  logic [LOW_W-1:0]   hw_set,
    input  logic [2:0]         pwr_state,
    input  logic               sci_en,
    output logic               wake_req,
    output logic               sci_req,
    output logic               smi_req
);

    logic [GPI_N-1:0] gpi_active;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] enable_q;
    logic             sel_status;
    logic             en_wr;

    assign sel_status = (reg_sel_e'(reg_addr) == REG_STATUS);
    assign en_wr      = reg_wr && !sel_status;
    assign clr_vec    = (reg_wr && sel_status) ? reg_wdata : '0;
    assign set_vec    = {gpi_active, hw_set & LOW_SRC_MASK};
    assign reg_rdata  = sel_status ? status_q : enable_q;

    gpe_gpi_detect #(.GPI_N(GPI_N)) u_detect (
        .gpi_pin      (gpi_pin),
        .gpi_is_input (gpi_is_input),
        .gpi_invert   (gpi_invert),
        .gpi_active   (gpi_active)
    );

    gpe_status_regs #(
        .REG_W     (REG_W),
        .LOW_W     (LOW_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .en_wr    (en_wr),
        .en_wdata (reg_wdata),
        .status_q (status_q),
        .enable_q (enable_q)
    );

    gpe_req_logic #(.GPI_N(GPI_N), .LOW_W(LOW_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .gpi_route (gpi_route),
        .pwr_state (pwr_state),
        .sci_en    (sci_en),
        .wake_req  (wake_req),
        .sci_req   (sci_req),
        .smi_req   (smi_req)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> ((status_q == '0) && (enable_q == '0)));

endmodule

// File: tb/gpe_event_router_test.sv
module gpe_event_router_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] gpi_pin = '0;
    logic [15:0] gpi_is_input = '1;
    logic [15:0] gpi_invert = '0;
    logic [31:0] gpi_route = '0;
    logic [15:0] hw_set = '0;
    logic [2:0]  pwr_state = 3'd0;
    logic        sci_en = 1'b1;
    logic        wake_req;
    logic        sci_req;
    logic        smi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpe_event_router uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpi_pin(gpi_pin), .gpi_is_input(gpi_is_input), .gpi_invert(gpi_invert),
        .gpi_route(gpi_route), .hw_set(hw_set), .pwr_state(pwr_state), .sci_en(sci_en),
        .wake_req(wake_req), .sci_req(sci_req), .smi_req(smi_req)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] val);
        reg_addr = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] val);
        reg_wr = 1'b1;
        reg_addr = sel;
        reg_wdata = val;
        step();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic clear_all();
        write_reg(1'b0, 32'hFFFF_FFFF);
        write_reg(1'b1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1;
        hw_set = 16'h0003;
        step();
        step();
        rst = 1'b0;
        hw_set = '0;
        #1;
        read_reg(1'b0, v);
        check("R1", "status after reset", v, 32'h0);
        read_reg(1'b1, v);
        check("R1", "enable after reset", v, 32'h0);
        check("R1", "requests after reset", {29'd0, wake_req, sci_req, smi_req}, 32'h0);
    endtask

    task automatic t_gpi_set();
        logic [31:0] v;
        @(negedge clk);
        gpi_pin = 16'h0001;
        step();
        read_reg(1'b0, v);
        check("R2", "GPI0 maps to bit16", v, 32'h0001_0000);
        @(negedge clk);
        gpi_pin = 16'h8000;
        step();
        gpi_pin = 16'h0000;
        step();
        read_reg(1'b0, v);
        check("R3", "bits stay set after pins drop", v, 32'h8001_0000);
        @(negedge clk);
        gpi_is_input = 16'hFFF7;
        gpi_pin = 16'h0008;
        step();
        gpi_pin = '0;
        gpi_is_input = '1;
        read_reg(1'b0, v);
        check("R2", "non-input pin ignored", v, 32'h8001_0000);
        @(negedge clk);
        gpi_invert = 16'h0020;
        step();
        gpi_invert = '0;
        read_reg(1'b0, v);
        check("R2", "inverted pin low sets bit21", v, 32'h8021_0000);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        @(negedge clk);
        hw_set = 16'h0006;
        gpi_pin = 16'h0001;
        step();
        hw_set = '0;
        gpi_pin = '0;
        write_reg(1'b0, 32'h0001_0000);
        read_reg(1'b0, v);
        check("R4", "write-1 clears only bit16", v, 32'h0000_0006);
        write_reg(1'b0, 32'h0);
        read_reg(1'b0, v);
        check("R4", "write-0 leaves bits", v, 32'h0000_0006);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        hw_set = 16'h0004;
        write_reg(1'b0, 32'h0000_0004);
        hw_set = '0;
        read_reg(1'b0, v);
        check("R5", "set beats same-cycle clear", v, 32'h0000_0004);
        write_reg(1'b0, 32'h0000_0004);
        read_reg(1'b0, v);
        check("R5", "clear after set released", v, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        @(negedge clk);
        hw_set = 16'h0002;
        gpi_pin = 16'h0101;
        step();
        hw_set = '0;
        gpi_pin = '0;
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        read_reg(1'b0, v);
        check("R6", "soft reset clears GPI half only", v, 32'h0000_0002);
        clear_all();
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        @(negedge clk);
        hw_set = 16'hFFFF;
        step();
        hw_set = '0;
        read_reg(1'b0, v);
        check("R7", "status bit15 stays 0", v, 32'h0000_7FFF);
        write_reg(1'b1, 32'hFFFF_FFFF);
        read_reg(1'b1, v);
        check("R7", "enable bit15 reads 0", v, 32'hFFFF_7FFF);
        read_reg(1'b0, v);
        check("R12", "enable write leaves status", v, 32'h0000_7FFF);
        write_reg(1'b1, 32'h1234_0042);
        read_reg(1'b1, v);
        check("R12", "enable readback", v, 32'h1234_0042);
        clear_all();
    endtask

    task automatic t_usb();
        logic [31:0] v;
        @(negedge clk);
        pwr_state = 3'd3;
        write_reg(1'b1, 32'h0000_4000);
        hw_set = 16'h4000;
        step();
        hw_set = '0;
        read_reg(1'b0, v);
        check("R8", "USB status bit14", v, 32'h0000_4000);
        check("R8", "USB wake in S3", {31'd0, wake_req}, 32'h1);
        check("R9", "no SCI/SMI in S3", {30'd0, sci_req, smi_req}, 32'h0);
        write_reg(1'b0, 32'h0000_4000);
        #1;
        check("R8", "wake drops after clear", {31'd0, wake_req}, 32'h0);
        pwr_state = 3'd0;
        clear_all();
    endtask

    task automatic t_wake();
        @(negedge clk);
        write_reg(1'b1, 32'h0001_0000);
        gpi_pin = 16'h0001;
        step();
        gpi_pin = '0;
        pwr_state = 3'd0;
        #1;
        check("R9", "no wake in S0", {31'd0, wake_req}, 32'h0);
        pwr_state = 3'd5;
        #1;
        check("R9", "wake in S5", {31'd0, wake_req}, 32'h1);
        pwr_state = 3'd1;
        #1;
        check("R9", "wake in S1", {31'd0, wake_req}, 32'h1);
        write_reg(1'b1, 32'h0);
        #1;
        check("R9", "no wake when disabled", {31'd0, wake_req}, 32'h0);
        pwr_state = 3'd0;
        clear_all();
    endtask

    task automatic t_low_irq();
        @(negedge clk);
        write_reg(1'b1, 32'h0000_0008);
        hw_set = 16'h0008;
        step();
        hw_set = '0;
        sci_en = 1'b1;
        #1;
        check("R10", "low bit SCI with sci_en=1", {30'd0, sci_req, smi_req}, 32'h2);
        sci_en = 1'b0;
        #1;
        check("R10", "low bit SMI with sci_en=0", {30'd0, sci_req, smi_req}, 32'h1);
        sci_en = 1'b1;
        clear_all();
    endtask

    task automatic t_route();
        @(negedge clk);
        write_reg(1'b1, 32'h0004_0000);
        gpi_pin = 16'h0004;
        step();
        gpi_pin = '0;
        sci_en = 1'b1;
        gpi_route = 32'h0000_0000;
        #1;
        check("R11", "route 00 none", {30'd0, sci_req, smi_req}, 32'h0);
        gpi_route = 32'h0000_0010;
        #1;
        check("R11", "route 01 SMI", {30'd0, sci_req, smi_req}, 32'h1);
        gpi_route = 32'h0000_0020;
        #1;
        check("R11", "route 10 SCI with sci_en=1", {30'd0, sci_req, smi_req}, 32'h2);
        sci_en = 1'b0;
        #1;
        check("R11", "route 10 SMI with sci_en=0", {30'd0, sci_req, smi_req}, 32'h1);
        gpi_route = 32'h0000_0030;
        #1;
        check("R11", "route 11 none", {30'd0, sci_req, smi_req}, 32'h0);
        gpi_route = '0;
        sci_en = 1'b1;
        clear_all();
    endtask

    initial begin
        t_reset();
        t_gpi_set();
        t_w1c();
        t_set_wins();
        t_soft_reset();
        t_reserved();
        t_usb();
        t_wake();
        t_low_irq();
        t_route();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule